// File: doc/BRIEF.md
# Protection-Bit Status Writer

This block is the host-side sequencer that changes the block-protection bits of a serial configuration memory. A single-cycle start request carries the new status byte. The block then runs three chip-select windows on a four-wire serial link. The first window carries the write-enable command. The second carries the write-status opcode followed by the new byte. The third carries a read-status command and then keeps chip select low. In that window the block clocks in repeated status bytes until the write-in-progress flag clears.

The serial clock comes from a built-in divider of the system clock. It idles low. The memory samples data on its rising edge, and the block changes data on its falling edge. Chip select returns high between windows and stays high for a fixed guard time. The wait for the memory's self-timed write cycle is bounded. If the busy flag is still set after a parameterised number of system cycles, counted from the end of the write-status window, the block gives up. It closes the link, raises an error pulse and returns to idle. A successful run ends with a done pulse. While a run is in progress, further start requests are dropped.

Top module: `prot_status_writer`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and busy_o, done_o and err_o are all 0.
- R2: The first chip-select-low window after an accepted start carries exactly one byte, the write-enable command 8'h06. No other window comes before it.
- R3: The second window carries exactly two bytes and a whole number of bytes' worth of clocks: opcode 8'h01 and then the status byte captured at start, each sent MSB first.
- R4: SPI mode 0. sclk_o idles at 0 and is never 1 while cs_n_o is 1. mosi_o is valid at each rising edge. sclk_o is 0 whenever cs_n_o rises. cs_n_o rises in the cycle right after the falling edge that ends the last byte of a window.
- R5: Between consecutive windows of one run, cs_n_o stays high for exactly CS_GAP system cycles. CS_GAP must be 2 or more.
- R6: The third window sends opcode 8'h05 and then fill bytes 8'h00. It stays open until the first received status byte whose bit 0 (write in progress) is 0. Bits 7..1 of the status byte are ignored.
- R7: busy_o is 1 from the cycle after an accepted start until the run ends. done_o is a one-cycle pulse with cs_n_o already 1 and busy_o 0.
- R8: Bit 0 may never clear. In that case err_o pulses for one cycle exactly TIMEOUT_CYC system cycles after the cycle in which cs_n_o rose at the end of the write-status window. At that point cs_n_o is 1 and busy_o is 0, and a later start runs normally.
- R9: A start request while busy_o is 1 is ignored. It neither restarts the sequence nor changes the byte that is written.
- R10: Within a byte, each high phase of sclk_o lasts exactly CLK_DIV system cycles, and so does each low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to write a new status byte |
| status_i | input | 8 | New status byte, captured with an accepted start |
| miso_i | input | 1 | Serial data from the memory |
| sclk_o | output | 1 | Serial clock to the memory |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: protection bits written and write finished |
| err_o | output | 1 | One-cycle pulse: busy flag did not clear within the timeout |

## Verification
The bench builds the block with CLK_DIV = 2, CS_GAP = 3 and TIMEOUT_CYC = 600. At these values a whole run is a few hundred cycles. That makes it possible to sweep every one of the 256 status bytes, with zero to three busy reads in the poll window and stray start pulses mixed in. The short timeout lets a run in which the busy flag never clears reach the error path. The bench then checks the exact error latency and that a following run recovers. The divider value of 2 exercises the divider's count and still keeps each sclk phase short enough to measure edge by edge.

// File: rtl/prot_wr_pkg.sv
package prot_wr_pkg;

  localparam logic [7:0] CMD_WR_ENABLE = 8'h06;
  localparam logic [7:0] CMD_WR_STATUS = 8'h01;
  localparam logic [7:0] CMD_RD_STATUS = 8'h05;
  localparam logic [7:0] POLL_FILL     = 8'h00;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ENABLE,
    SQ_GAP_A,
    SQ_WR_OP,
    SQ_WR_DATA,
    SQ_GAP_B,
    SQ_RD_OP,
    SQ_RD_POLL
  } seq_state_t;

  // write-in-progress lives in bit 0 of the returned status byte
  function automatic logic wip_set(input logic [7:0] stat);
    return stat[0];
  endfunction

  // states in which the completion timer runs
  function automatic logic timer_phase(input seq_state_t s);
    return (s == SQ_GAP_B) || (s == SQ_RD_OP) || (s == SQ_RD_POLL);
  endfunction

endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      logic          wrap;
      assign wrap = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!en || wrap)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end
      assign tick = en && wrap;
    end
  endgenerate
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       abort,
  input  logic [7:0] tx,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  logic [7:0] sr;
  logic [2:0] nbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      rx     <= '0;
      nbit   <= '0;
      active <= 1'b0;
      sclk   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sclk   <= 1'b0;
      end else if (go) begin
        active <= 1'b1;
        sr     <= tx;
        sclk   <= 1'b0;
        nbit   <= '0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (nbit == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            nbit <= nbit + 1'b1;
            sr   <= {sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = sr[7];

  // R3: a byte finishes with the clock low and the engine stopped
  a_r3_byte_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && !active));

  // R10: the clock only moves while a byte is being shifted
  a_r10_clock_held: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !go |=> $stable(sclk) || !sclk);
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int LIMIT = 1_600_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  assign expire = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prot_status_writer.sv
module prot_status_writer
  import prot_wr_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int CS_GAP      = 4,
  parameter int TIMEOUT_CYC = 1_600_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] status_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       cs_n_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int GW = $clog2(CS_GAP + 1);

  seq_state_t    st;
  logic [7:0]    hold_q;
  logic [7:0]    ld_byte;
  logic          ld;
  logic [GW-1:0] gap_cnt;
  logic          cs_q, done_q, err_q;

  // named internal events
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       eng_active;
  logic       tick;
  logic       tmo_expire;
  logic       tmo_clear;
  logic       gap_over;

  assign gap_over  = (gap_cnt == GW'(CS_GAP - 1));
  assign tmo_clear = (st == SQ_WR_DATA) && byte_done;

  sclk_divider #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(eng_active), .tick(tick)
  );

  byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .go(ld), .abort(tmo_expire), .tx(ld_byte),
    .tick(tick), .miso(miso_i), .active(eng_active), .sclk(sclk_o),
    .mosi(mosi_o), .done(byte_done), .rx(rx_byte)
  );

  poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmo_clear), .run(timer_phase(st)),
    .expire(tmo_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      hold_q  <= '0;
      ld_byte <= '0;
      ld      <= 1'b0;
      gap_cnt <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ld     <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (tmo_expire) begin
        cs_q  <= 1'b1;
        err_q <= 1'b1;
        st    <= SQ_IDLE;
      end else begin
        case (st)
          SQ_IDLE: if (start_i) begin
            hold_q  <= status_i;
            cs_q    <= 1'b0;
            ld      <= 1'b1;
            ld_byte <= CMD_WR_ENABLE;
            st      <= SQ_ENABLE;
          end
          SQ_ENABLE: if (byte_done) begin
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            st      <= SQ_GAP_A;
          end
          SQ_GAP_A: if (gap_over) begin
            cs_q    <= 1'b0;
            ld      <= 1'b1;
            ld_byte <= CMD_WR_STATUS;
            st      <= SQ_WR_OP;
          end else gap_cnt <= gap_cnt + 1'b1;
          SQ_WR_OP: if (byte_done) begin
            ld      <= 1'b1;
            ld_byte <= hold_q;
            st      <= SQ_WR_DATA;
          end
          SQ_WR_DATA: if (byte_done) begin
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            st      <= SQ_GAP_B;
          end
          SQ_GAP_B: if (gap_over) begin
            cs_q    <= 1'b0;
            ld      <= 1'b1;
            ld_byte <= CMD_RD_STATUS;
            st      <= SQ_RD_OP;
          end else gap_cnt <= gap_cnt + 1'b1;
          SQ_RD_OP: if (byte_done) begin
            ld      <= 1'b1;
            ld_byte <= POLL_FILL;
            st      <= SQ_RD_POLL;
          end
          SQ_RD_POLL: if (byte_done) begin
            if (wip_set(rx_byte)) begin
              ld      <= 1'b1;
              ld_byte <= POLL_FILL;
            end else begin
              cs_q   <= 1'b1;
              done_q <= 1'b1;
              st     <= SQ_IDLE;
            end
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign cs_n_o = cs_q;
  assign busy_o = (st != SQ_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R4: clock pulses only inside a chip-select window
  a_r4_clock_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);

  // R4: the window closes with the clock low
  a_r4_close_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> !sclk_o);

  // R5: inside a run, chip select stays high for more than one cycle
  a_r5_guard_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) && busy_o |=> cs_n_o);

  // R7: completion and error never coincide
  a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R8: on timeout the link is closed and the block is idle
  a_r8_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cs_n_o && !busy_o && !sclk_o));

  // R9: the captured byte does not move during a run
  a_r9_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(hold_q));
endmodule

// File: tb/prot_status_writer_test.sv
module prot_status_writer_test;
  localparam int DIV = 2;
  localparam int GAP = 3;
  localparam int TMO = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic       miso_i;
  logic       sclk_o, cs_n_o, mosi_o, busy_o, done_o, err_o;

  prot_status_writer #(.CLK_DIV(DIV), .CS_GAP(GAP), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
    .miso_i(miso_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int         cyc = 0;
  int         hi_run = 0;
  int         fr_cnt = 0;
  int         fr_nb[3];
  logic [7:0] fr_b[3][16];
  int         rises = 0;
  int         rise_cyc = 0;
  int         busy_n = 0;
  int         wr_end_cyc = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] model_hi = 8'h00;
  logic [7:0] cur_stat;
  bit         chk_rise = 1'b1;
  logic       prev_cs = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cs_n_o) hi_run++;
    else        hi_run = 0;
  end

  always_comb begin
    if (fr_cnt == 3 && (rises / 8) >= 1)
      cur_stat = {model_hi[7:1], ((rises / 8) <= busy_n)};
    else
      cur_stat = 8'hA5;
  end
  assign miso_i = cur_stat[3'(7 - (rises % 8))];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n_o && prev_cs) begin
        if (fr_cnt > 0) chk(hi_run == GAP, "R5 chip-select guard cycles", hi_run, GAP);
        fr_cnt++;
        rises = 0;
      end
      if (cs_n_o && !prev_cs) begin
        chk(sclk_o == 1'b0, "R4 clock low when window closes", int'(sclk_o), 0);
        if (chk_rise) chk(rises % 8 == 0, "R3 whole bytes per window", rises % 8, 0);
        if (fr_cnt == 2) wr_end_cyc = cyc;
      end
    end
    prev_cs = cs_n_o;
  end

  always @(posedge sclk_o) begin
    if (rst_n) begin
      chk(cs_n_o == 1'b0, "R4 clock rise inside window", int'(cs_n_o), 0);
      sh = {sh[6:0], mosi_o};
      rises++;
      rise_cyc = cyc;
      if (rises % 8 == 0 && fr_cnt >= 1 && fr_cnt <= 3) begin
        if (fr_nb[fr_cnt-1] < 16) fr_b[fr_cnt-1][fr_nb[fr_cnt-1]] = sh;
        fr_nb[fr_cnt-1]++;
      end
    end
  end

  always @(negedge sclk_o) begin
    if (rst_n && chk_rise)
      chk(cyc - rise_cyc == DIV, "R10 clock high phase", cyc - rise_cyc, DIV);
  end

  // ---------------- one run ----------------
  task automatic run_once(input logic [7:0] d, input int nbusy, input bit tmo, input bit poke);
    int waited;
    fr_cnt = 0;
    for (int i = 0; i < 3; i++) fr_nb[i] = 0;
    busy_n = nbusy;
    model_hi = d ^ 8'h5A;
    chk_rise = !tmo;
    @(negedge clk);
    status_i = d;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    status_i = ~d;
    chk(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    waited = 0;
    while (!done_o && !err_o) begin
      @(negedge clk);
      waited++;
      start_i = (poke && waited == 40);
    end
    start_i = 1'b0;
    if (tmo) begin
      chk(err_o == 1'b1, "R8 error pulse", int'(err_o), 1);
      chk(done_o == 1'b0, "R8 no done on timeout", int'(done_o), 0);
      chk(cyc - wr_end_cyc == TMO, "R8 timeout latency", cyc - wr_end_cyc, TMO);
      chk(cs_n_o && !busy_o, "R8 closed and idle", int'({cs_n_o, busy_o}), 2);
    end else begin
      chk(done_o == 1'b1, "R7 done pulse", int'(done_o), 1);
      chk(cs_n_o && !busy_o, "R7 closed and idle at done", int'({cs_n_o, busy_o}), 2);
      chk(fr_cnt == 3, "R2 window count", fr_cnt, 3);
      chk(fr_nb[0] == 1, "R2 enable window length", fr_nb[0], 1);
      chk(fr_b[0][0] == 8'h06, "R2 enable command", fr_b[0][0], 8'h06);
      chk(fr_nb[1] == 2, "R3 write window length", fr_nb[1], 2);
      chk(fr_b[1][0] == 8'h01, "R3 write opcode", fr_b[1][0], 8'h01);
      chk(fr_b[1][1] == d, poke ? "R9 byte kept despite start" : "R3 data byte",
          fr_b[1][1], d);
      chk(fr_nb[2] == 2 + nbusy, "R6 status reads", fr_nb[2], 2 + nbusy);
      chk(fr_b[2][0] == 8'h05, "R6 read opcode", fr_b[2][0], 8'h05);
      chk(fr_b[2][1] == 8'h00, "R6 fill byte", fr_b[2][1], 8'h00);
    end
    @(negedge clk);
    chk(!done_o && !err_o, "R7 single-cycle outcome", int'({done_o, err_o}), 0);
    repeat (GAP + 4) @(negedge clk);
    chk(cs_n_o && !busy_o, "R9 no restart after stray start", int'({cs_n_o, busy_o}), 2);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 chip select in reset", int'(cs_n_o), 1);
    chk(sclk_o == 1'b0, "R1 clock in reset", int'(sclk_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1 flags after reset",
        int'({busy_o, done_o, err_o}), 0);
    chk(cs_n_o && !sclk_o, "R1 link idle after reset", int'({cs_n_o, sclk_o}), 2);
    for (int d = 0; d < 256; d++)
      run_once(8'(d), d % 4, 1'b0, (d % 16) == 7);
    run_once(8'hC3, 1000, 1'b1, 1'b0);
    run_once(8'h3C, 2, 1'b0, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule